// File: doc/BRIEF.md
# Synaptic Pulse Program Sequencer

This controller drives the programming of a single transistor-plus-resistive-element synapse cell. It produces the digital codes for the word-line, source-line and bit-line drivers, the write enable and the polarity flag. After each cell update it also issues a read strobe at low bias and captures the converter result that comes back. One start command runs a full training cycle. The cycle first applies a rising series of set pulses (potentiation). It then applies a series of depression steps. Each depression step is a full-strength reset pulse followed by a set pulse whose word-line amplitude falls step by step. Cycles can repeat a set number of times or run without end for endurance work. An abort input stops the run at once.

Every write leaves the source and bit lines at a fixed drive code. Every write that completes a cell update is followed by a programmable settle delay and then a read. The read result is presented with the index of the conductance state it belongs to. All voltages are DAC codes at 1 mV per LSB. Pulse width and settle delay are given in nanoseconds and microseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `spp_seq`

## Requirements
- R1: After reset all three drive codes are 0, `wr_en`, `wr_reset`, `rd_strobe`, `rd_valid`, `cycle_done` and `busy` are low, and `upd_count` is 0.
- R2: In idle, `start` latches `cfg_npulse` and `cfg_cycles`, and the first write pulse is on the outputs in the next cycle. `busy` is high from then until the run returns to idle. `start` and any change of the configuration inputs during a run have no effect on the outputs.
- R3: The potentiation phase has N pulses, where N is `cfg_npulse` and values below 2 count as 2. Pulse k (k = 0..N-1) holds `wr_en`=1, `wr_reset`=0, source and bit line at 2000, and word line at 1200 + floor(1200*k/(N-1)) for PULSE_CYC cycles.
- R4: Depression step k is a reset pulse (word line 2400, `wr_reset`=1) of PULSE_CYC cycles, then GAP_CYC cycles of all-zero drive, then a set pulse at word line 2400 - floor(1200*k/(N-1)). Both pulses keep source and bit line at 2000.
- R5: Each potentiation pulse, and each set pulse of a depression step, is followed by DELAY_CYC cycles of zero drive. Then comes one read cycle with word line 1200, source line 100, bit line 0 and `rd_strobe`=1, and then one zero-drive cycle before the next write.
- R6: The cycle after each read, `rd_valid` is high for one cycle. `rd_data` then carries the `adc_data` sampled in the read cycle, and `rd_index` is k in potentiation and N+k in depression.
- R7: `upd_count` goes up by exactly 1 after the last cycle of every write pulse, reset pulses included, and the new value is visible one cycle later. It is cleared only by reset.
- R8: `cycle_done` pulses for one cycle right after the zero-drive cycle that follows the last depression read. The next cycle's first potentiation pulse starts in that same cycle, or the block is idle there once `cfg_cycles` cycles have run. `cfg_cycles`=0 repeats without end.
- R9: `abort` puts the block in idle in the next cycle with zero drive and `busy` low. It suppresses a pending `rd_valid`, `cycle_done` and count increment, keeps `upd_count`, and wins over a `start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled only in idle) |
| abort | input | 1 | Stop immediately and return to idle |
| cfg_npulse | input | NW | Pulses per phase (values below 2 count as 2) |
| cfg_cycles | input | CW | Full cycles to run, 0 = endless |
| adc_data | input | ADC_W | Read converter result |
| wl_code | output | DAC_W | Word-line DAC code |
| sl_code | output | DAC_W | Source-line DAC code |
| bl_code | output | DAC_W | Bit-line DAC code |
| wr_en | output | 1 | Write pulse active |
| wr_reset | output | 1 | Active write is a reset pulse |
| rd_strobe | output | 1 | Read bias applied, converter sampled |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | ADC_W | Captured read result |
| rd_index | output | NW+1 | Conductance state index of the result |
| busy | output | 1 | Run in progress |
| cycle_done | output | 1 | One full cycle completed (one cycle) |
| upd_count | output | CNT_W | Running count of write pulses |

## Verification
Two events are made to land together: an abort in the same cycle as a read strobe, and an abort in the same idle cycle as a start. The bench counts its steps through a run to place the abort on the read cycle. It then requires the next cycle to show idle with `rd_valid` low and an unchanged update count. For the second case it drives both inputs at once and requires the block to stay idle. A start pulse and a change of pulse count in the middle of a run are checked the same way, against the unchanged expected trace.

// File: rtl/spp_pkg.sv
package spp_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WRITE,
      S_GAP,
      S_RWAIT,
      S_READ,
      S_NEXT
   } spp_state_e;
endpackage

// File: rtl/spp_timer.sv
module spp_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - TW'(1);
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/spp_ramp.sv
module spp_ramp #(
   parameter int DAC_W = 12,
   parameter int NW    = 8,
   parameter int SPAN  = 1200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [NW-1:0]    n_in,
   output logic [DAC_W-1:0] off
);
   localparam int WW = (DAC_W > NW) ? DAC_W : NW;

   logic [WW-1:0] span_w, den_c, q_c, rem_c;
   logic [WW-1:0] q_r, rem_r, den_r, acc_r;
   logic [WW:0]   sum;
   logic [DAC_W-1:0] off_r;

   assign span_w = WW'(SPAN);
   assign den_c  = (n_in < NW'(2)) ? WW'(1) : (WW'(n_in) - WW'(1));
   assign q_c    = span_w / den_c;
   assign rem_c  = span_w % den_c;
   assign sum    = {1'b0, acc_r} + {1'b0, rem_r};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r   <= '0;
         rem_r <= '0;
         den_r <= '0;
         acc_r <= '0;
         off_r <= '0;
      end else if (load) begin
         q_r   <= q_c;
         rem_r <= rem_c;
         den_r <= den_c;
         acc_r <= '0;
         off_r <= '0;
      end else if (adv) begin
         if (sum >= {1'b0, den_r}) begin
            acc_r <= WW'(sum - {1'b0, den_r});
            off_r <= off_r + DAC_W'(q_r) + DAC_W'(1);
         end else begin
            acc_r <= WW'(sum);
            off_r <= off_r + DAC_W'(q_r);
         end
      end
   end

   assign off = off_r;

   // R3
   off_le_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      off_r <= DAC_W'(SPAN));
endmodule

// File: rtl/spp_seq.sv
module spp_seq
   import spp_pkg::*;
#(
   parameter int DAC_W    = 12,
   parameter int ADC_W    = 12,
   parameter int NW       = 8,
   parameter int CW       = 16,
   parameter int CNT_W    = 32,
   parameter int CLK_MHZ  = 100,
   parameter int PULSE_NS = 200,
   parameter int DELAY_US = 100,
   parameter int GAP_CYC  = 2,
   parameter int WL_LO    = 1200,
   parameter int WL_HI    = 2400,
   parameter int DRIVE    = 2000,
   parameter int RD_BIAS  = 100,
   parameter int WL_RD    = 1200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [NW-1:0]    cfg_npulse,
   input  logic [CW-1:0]    cfg_cycles,
   input  logic [ADC_W-1:0] adc_data,
   output logic [DAC_W-1:0] wl_code,
   output logic [DAC_W-1:0] sl_code,
   output logic [DAC_W-1:0] bl_code,
   output logic             wr_en,
   output logic             wr_reset,
   output logic             rd_strobe,
   output logic             rd_valid,
   output logic [ADC_W-1:0] rd_data,
   output logic [NW:0]      rd_index,
   output logic             busy,
   output logic             cycle_done,
   output logic [CNT_W-1:0] upd_count
);
   localparam int PULSE_CYC = CLK_MHZ * PULSE_NS / 1000;
   localparam int DELAY_CYC = CLK_MHZ * DELAY_US;
   localparam int SPAN      = WL_HI - WL_LO;
   localparam int TMAX_A    = (PULSE_CYC > DELAY_CYC) ? PULSE_CYC : DELAY_CYC;
   localparam int TMAX      = (TMAX_A > GAP_CYC) ? TMAX_A : GAP_CYC;
   localparam int TW        = $clog2(TMAX + 1);
   localparam int IW        = NW + 1;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("pulse width shorter than one clock");
   end
   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("settle delay shorter than one clock");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("reset-to-set gap must be at least one clock");
   end
   if (WL_HI <= WL_LO || WL_HI >= (1 << DAC_W)) begin : g_bad_wl
      $error("word-line range does not fit the DAC");
   end
   if (DRIVE >= (1 << DAC_W) || RD_BIAS >= (1 << DAC_W) || WL_RD >= (1 << DAC_W)) begin : g_bad_bias
      $error("bias code does not fit the DAC");
   end
   if (NW < 2) begin : g_bad_nw
      $error("pulse count field too narrow");
   end

   spp_state_e    st;
   logic [NW-1:0] n_r, k, n_clamp, ramp_n;
   logic [CW-1:0] cyc_left;
   logic          dep, sub;
   logic          last_k;
   logic          t_load, t_exp;
   logic [TW-1:0] t_val;
   logic          r_load, r_adv;
   logic [DAC_W-1:0] off;

   assign n_clamp = (cfg_npulse < NW'(2)) ? NW'(2) : cfg_npulse;
   assign ramp_n  = (st == S_IDLE) ? n_clamp : n_r;
   assign last_k  = (k == n_r - NW'(1));

   // timer load points: entry to a pulse, a gap or a settle delay
   always_comb begin
      t_load = 1'b0;
      t_val  = TW'(PULSE_CYC - 1);
      if (!abort) begin
         unique case (st)
            S_IDLE:  t_load = start;
            S_GAP:   t_load = t_exp;
            S_NEXT:  t_load = 1'b1;
            S_WRITE: begin
               t_load = t_exp;
               t_val  = (dep && !sub) ? TW'(GAP_CYC - 1) : TW'(DELAY_CYC - 1);
            end
            default: t_load = 1'b0;
         endcase
      end
   end

   assign r_load = !abort && (((st == S_IDLE) && start) || ((st == S_NEXT) && last_k));
   assign r_adv  = !abort && (st == S_NEXT) && !last_k;

   spp_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_exp)
   );

   spp_ramp #(.DAC_W(DAC_W), .NW(NW), .SPAN(SPAN)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (r_load),
      .adv   (r_adv),
      .n_in  (ramp_n),
      .off   (off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         n_r        <= NW'(2);
         k          <= '0;
         cyc_left   <= '0;
         dep        <= 1'b0;
         sub        <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         rd_index   <= '0;
         cycle_done <= 1'b0;
         upd_count  <= '0;
      end else begin
         rd_valid   <= 1'b0;
         cycle_done <= 1'b0;
         if (abort) begin
            st <= S_IDLE;
         end else begin
            unique case (st)
               S_IDLE: if (start) begin
                  n_r      <= n_clamp;
                  cyc_left <= cfg_cycles;
                  k        <= '0;
                  dep      <= 1'b0;
                  sub      <= 1'b0;
                  st       <= S_WRITE;
               end
               S_WRITE: if (t_exp) begin
                  upd_count <= upd_count + CNT_W'(1);
                  if (dep && !sub) begin
                     sub <= 1'b1;
                     st  <= S_GAP;
                  end else begin
                     st  <= S_RWAIT;
                  end
               end
               S_GAP:   if (t_exp) st <= S_WRITE;
               S_RWAIT: if (t_exp) st <= S_READ;
               S_READ: begin
                  rd_data  <= adc_data;
                  rd_index <= dep ? (IW'(n_r) + IW'(k)) : IW'(k);
                  rd_valid <= 1'b1;
                  st       <= S_NEXT;
               end
               S_NEXT: begin
                  sub <= 1'b0;
                  if (last_k) begin
                     k <= '0;
                     if (!dep) begin
                        dep <= 1'b1;
                        st  <= S_WRITE;
                     end else begin
                        dep        <= 1'b0;
                        cycle_done <= 1'b1;
                        if (cyc_left == CW'(1)) begin
                           st <= S_IDLE;
                        end else begin
                           if (cyc_left != '0) cyc_left <= cyc_left - CW'(1);
                           st <= S_WRITE;
                        end
                     end
                  end else begin
                     k  <= k + NW'(1);
                     st <= S_WRITE;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // drive decode from the current step
   always_comb begin
      wl_code   = '0;
      sl_code   = '0;
      bl_code   = '0;
      wr_en     = 1'b0;
      wr_reset  = 1'b0;
      rd_strobe = 1'b0;
      if (st == S_WRITE) begin
         wr_en   = 1'b1;
         sl_code = DAC_W'(DRIVE);
         bl_code = DAC_W'(DRIVE);
         if (!dep)
            wl_code = DAC_W'(WL_LO) + off;
         else if (!sub) begin
            wl_code  = DAC_W'(WL_HI);
            wr_reset = 1'b1;
         end else
            wl_code = DAC_W'(WL_HI) - off;
      end else if (st == S_READ) begin
         wl_code   = DAC_W'(WL_RD);
         sl_code   = DAC_W'(RD_BIAS);
         rd_strobe = 1'b1;
      end
   end

   assign busy = (st != S_IDLE);

   // R7
   upd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_count != $past(upd_count)) |->
         ((upd_count == $past(upd_count) + CNT_W'(1)) && $past(wr_en)));

   // R6
   rd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_strobe));

   // R5
   read_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |-> !$past(wr_en));

   // R8
   done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_done |-> $past(rd_valid));

   // R9
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !wr_en && !rd_strobe && (wl_code == '0) && !rd_valid && !cycle_done));
endmodule

// File: tb/sim_spp_seq.sv
module sim_spp_seq;
   localparam int CLK_PERIOD = 10;
   localparam int P = 3;
   localparam int D = 100;
   localparam int G = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        abort = 1'b0;
   logic [7:0]  cfg_npulse = '0;
   logic [15:0] cfg_cycles = '0;
   logic [11:0] adc_data = '0;
   logic [11:0] wl_code, sl_code, bl_code;
   logic        wr_en, wr_reset, rd_strobe, rd_valid, busy, cycle_done;
   logic [11:0] rd_data;
   logic [8:0]  rd_index;
   logic [31:0] upd_count;

   int vectors = 0;
   int fails = 0;
   bit finished = 0;

   int  cnt_model = 0;
   bit  pend_cnt = 0, pend_rv = 0, pend_done = 0;
   int  pend_data = 0, pend_idx = 0;
   int  stepno = 0;
   int  inj_start = -1;
   int  steps_left = -1;
   bit  stopped = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spp_seq #(
      .CLK_MHZ(100), .PULSE_NS(30), .DELAY_US(1), .GAP_CYC(G)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .cfg_npulse(cfg_npulse), .cfg_cycles(cfg_cycles), .adc_data(adc_data),
      .wl_code(wl_code), .sl_code(sl_code), .bl_code(bl_code),
      .wr_en(wr_en), .wr_reset(wr_reset), .rd_strobe(rd_strobe),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_index(rd_index),
      .busy(busy), .cycle_done(cycle_done), .upd_count(upd_count)
   );

   task automatic cmp(string req, string what, int act, int exp, inout bit bad);
      if (act != exp) begin
         $display("FAIL %s %s step %0d: actual %0d expected %0d", req, what, stepno, act, exp);
         bad = 1;
      end
   endtask

   task automatic emit(int wl, int sl, int bl, bit wr, bit rs, bit rd, bit bz,
                       bit pulse_end, bit is_read, int idx, bit cyc_end, string req);
      bit bad;
      bit e_rv, e_done;
      if (stopped) return;
      @(negedge clk);
      if (pend_cnt) cnt_model++;
      pend_cnt = 0;
      e_rv = pend_rv;
      e_done = pend_done;
      pend_rv = 0;
      pend_done = 0;
      bad = 0;
      cmp(req, "wl_code", int'(wl_code), wl, bad);
      cmp(req, "sl_code", int'(sl_code), sl, bad);
      cmp(req, "bl_code", int'(bl_code), bl, bad);
      cmp(req, "wr_en", int'(wr_en), int'(wr), bad);
      cmp(req, "wr_reset", int'(wr_reset), int'(rs), bad);
      cmp(req, "rd_strobe", int'(rd_strobe), int'(rd), bad);
      cmp("R2", "busy", int'(busy), int'(bz), bad);
      cmp("R6", "rd_valid", int'(rd_valid), int'(e_rv), bad);
      if (e_rv) begin
         cmp("R6", "rd_data", int'(rd_data), pend_data, bad);
         cmp("R6", "rd_index", int'(rd_index), pend_idx, bad);
      end
      cmp("R8", "cycle_done", int'(cycle_done), int'(e_done), bad);
      cmp("R7", "upd_count", int'(upd_count), cnt_model, bad);
      vectors++;
      if (bad) fails++;
      start = (stepno == inj_start);
      if (stepno == inj_start) cfg_npulse = 8'd7;
      abort = 0;
      adc_data = 12'((stepno * 53 + 7) & 12'hFFF);
      stepno++;
      if (pulse_end) pend_cnt = 1;
      if (is_read) begin
         pend_rv = 1;
         pend_data = int'(adc_data);
         pend_idx = idx;
      end
      if (cyc_end) pend_done = 1;
      if (steps_left > 0) begin
         steps_left--;
         if (steps_left == 0) stopped = 1;
      end
   endtask

   task automatic idle(string req);
      emit(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic run(int n, int cyc, int budget);
      int nn;
      int c;
      nn = (n < 2) ? 2 : n;
      c = 0;
      stopped = 0;
      steps_left = budget;
      cfg_npulse = 8'(n);
      cfg_cycles = 16'(cyc);
      start = 1;
      while ((cyc == 0 || c < cyc) && !stopped) begin
         for (int ph = 0; ph < 2; ph++) begin
            for (int k = 0; k < nn; k++) begin
               int off;
               off = (1200 * k) / (nn - 1);
               if (ph == 1) begin
                  for (int i = 0; i < P; i++) emit(2400, 2000, 2000, 1, 1, 0, 1, i == P-1, 0, 0, 0, "R4");
                  for (int i = 0; i < G; i++) emit(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4");
                  for (int i = 0; i < P; i++) emit(2400 - off, 2000, 2000, 1, 0, 0, 1, i == P-1, 0, 0, 0, "R4");
               end else begin
                  for (int i = 0; i < P; i++) emit(1200 + off, 2000, 2000, 1, 0, 0, 1, i == P-1, 0, 0, 0, "R3");
               end
               for (int i = 0; i < D; i++) emit(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5");
               emit(1200, 100, 0, 0, 0, 1, 1, 0, 1, ph * nn + k, 0, "R5");
               emit(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, (ph == 1) && (k == nn - 1), "R6");
            end
         end
         c++;
      end
      stopped = 0;
      steps_left = -1;
   endtask

   task automatic do_abort();
      abort = 1;
      pend_cnt = 0;
      pend_rv = 0;
      pend_done = 0;
      idle("R9");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      for (int i = 0; i < 3; i++) idle("R1");

      // R2 R3 R4: floor ramp with remainder, start and config change mid-run ignored
      inj_start = stepno + 60;
      run(10, 2, -1);
      inj_start = -1;
      for (int i = 0; i < 3; i++) idle("R8");

      // R3: pulse count below two counts as two
      run(1, 1, -1);
      for (int i = 0; i < 2; i++) idle("R8");

      // R3 R4: full 128-step ramp, 1200/127 leaves a remainder
      run(128, 1, -1);
      for (int i = 0; i < 2; i++) idle("R8");

      // R8: endless mode spans several cycles, then abort mid-run (R9)
      run(2, 0, 1000);
      do_abort();
      for (int i = 0; i < 2; i++) idle("R9");

      // R9: abort on the read strobe suppresses the result
      run(4, 0, P + D + 1);
      do_abort();
      idle("R9");

      // R9: abort and start in the same idle cycle
      cfg_npulse = 8'd3;
      cfg_cycles = 16'd1;
      start = 1;
      abort = 1;
      idle("R9");
      for (int i = 0; i < 2; i++) idle("R9");

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule